// File: doc/BRIEF.md
# Slow-Clock-Aligned Command Word Serializer

This block turns 16-bit command words into frames on a single serial command line. Each frame has a low start bit, the payload least significant bit first, and two high stop bits, with no parity. The block runs from a 40 MHz clock and holds every bit for four cycles, which gives 10 Mbit/s. A free-running divider produces a 5 MHz tick once every eight cycles, and a frame may only begin on one of those ticks. Because of this, every frame start lines up with the slow clock that the receivers divide down locally.

Commands reach the block in two ways. Four one-cycle strobes each post a fixed code: stop acquisition, start acquisition, clock resynchronisation, and link buffer reset. A valid/ready handshake carries any other word. Each source holds one pending request. When several are pending, they are sent in a fixed priority order, one frame per tick opportunity. The line rests high whenever no frame is being sent.

Top module: `fcs_serializer`

## Requirements
- R1: After reset the line is high, `busy` is low and `cmd_ready` is high.
- R2: A frame is one low start bit, then 16 payload bits with bit 0 first, then two high stop bits, with no parity bit. The line is high whenever no frame is being sent.
- R3: Each frame bit holds the line steady for exactly 4 clock cycles, so a frame lasts 76 cycles.
- R4: The first low cycle of a frame follows a clock edge whose index since the end of reset is a multiple of 8. Index 1 is the first edge with reset low.
- R5: The strobes send fixed codes: `req_stop` sends 0xE313, `req_start` sends 0xE311, `req_sync` sends 0xE000 and `req_bufrst` sends 0x0000.
- R6: `cmd_ready` is high while the generic slot is empty. A word accepted with `cmd_valid` and `cmd_ready` both high is sent unchanged, and `cmd_ready` is low in the cycle after acceptance.
- R7: When several requests are pending, they are sent in this order: stop, start, sync, buffer reset, generic word.
- R8: A pending frame starts on the first tick after the previous frame's stop bits end, so back-to-back frames start 80 cycles apart.
- R9: `busy` is high while a frame is being sent or any request is pending. It is low once the last frame ends and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A generic word is offered |
| cmd_data | input | 16 | Generic word to send |
| cmd_ready | output | 1 | Generic slot is empty |
| req_stop | input | 1 | Strobe: post the stop-acquisition code |
| req_start | input | 1 | Strobe: post the start-acquisition code |
| req_sync | input | 1 | Strobe: post the resynchronisation code |
| req_bufrst | input | 1 | Strobe: post the buffer-reset code |
| ser_out | output | 1 | Serial command line |
| busy | output | 1 | A frame is on the line or a request is pending |

## Verification
The bench measures where each frame starts relative to the end of reset. A design that starts frames on any free cycle, or that counts the divider with the wrong phase, gives start indices that are not multiples of eight. The bench posts all five requests in the same cycle and decodes the frames that follow. A priority inverted anywhere, or a pending request dropped, shows up as the wrong code sequence. The gap between back-to-back frames must be exactly 80 cycles: a design that starts the next frame right after the stop bits gives 76 cycles, and one that waits an extra tick gives 88. Sending the all-zero and all-high-byte codes catches a payload sent in reverse bit order, a missing stop bit or a bit period that is one cycle wrong.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CMD_W   = 16;
    localparam int STOP_N  = 2;
    localparam int FRAME_W = 1 + CMD_W + STOP_N;
    localparam int SRC_N   = 5;

    localparam logic [CMD_W-1:0] CODE_STOP  = 16'hE313;
    localparam logic [CMD_W-1:0] CODE_START = 16'hE311;
    localparam logic [CMD_W-1:0] CODE_SYNC  = 16'hE000;
    localparam logic [CMD_W-1:0] CODE_BRST  = 16'h0000;

    // Index order is also service priority (lowest first)
    typedef enum logic [2:0] {
        SRC_STOP  = 3'd0,
        SRC_START = 3'd1,
        SRC_SYNC  = 3'd2,
        SRC_BRST  = 3'd3,
        SRC_GEN   = 3'd4
    } src_e;

    typedef struct packed {
        logic             vld;
        src_e             src;
        logic [CMD_W-1:0] word;
    } pick_t;

    function automatic logic [FRAME_W-1:0] build_frame(input logic [CMD_W-1:0] w);
        return {{STOP_N{1'b1}}, w, 1'b0};
    endfunction

    function automatic logic [CMD_W-1:0] fixed_code(input src_e s);
        case (s)
            SRC_STOP:  return CODE_STOP;
            SRC_START: return CODE_START;
            SRC_SYNC:  return CODE_SYNC;
            default:   return CODE_BRST;
        endcase
    endfunction

endpackage

// File: rtl/fcs_tick.sv
module fcs_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == CNT_W'(DIV - 1)) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CNT_W'(DIV - 1));

endmodule

// File: rtl/fcs_arb.sv
module fcs_arb
    import fcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       strobes,   // stop, start, sync, bufrst at 0..3
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             cmd_ready,
    input  logic             take,
    output pick_t            pick,
    output logic             any_pend
);
    logic [SRC_N-1:0] pend, set_v, clr_v;
    logic [CMD_W-1:0] gen_q;
    logic [2:0]       sel;
    logic             accept;

    assign cmd_ready = !pend[SRC_GEN];
    assign accept    = cmd_valid && cmd_ready;
    assign set_v     = {accept, strobes};

    always_comb begin
        sel = 3'd0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (pend[i]) sel = 3'(i);
        end
    end

    always_comb begin
        pick.vld  = |pend;
        pick.src  = src_e'(sel);
        pick.word = (src_e'(sel) == SRC_GEN) ? gen_q : fixed_code(src_e'(sel));
        clr_v     = '0;
        if (take) clr_v[sel] = 1'b1;
    end

    assign any_pend = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            gen_q <= '0;
        end else begin
            pend <= (pend & ~clr_v) | set_v;
            if (accept) gen_q <= cmd_data;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R6
    AST_TAKE_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        take |-> pick.vld); // R7

endmodule

// File: rtl/fcs_shift.sv
module fcs_shift
    import fcs_pkg::*;
#(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  pick_t pick,
    output logic  take,
    output logic  ser_out,
    output logic  active
);
    localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int NB_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [PH_W-1:0]    ph;
    logic [NB_W-1:0]    nbit;
    logic               last_ph;

    assign take    = tick && !active && pick.vld;
    assign last_ph = (ph == PH_W'(CLKS_PER_BIT - 1));
    assign ser_out = active ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            shreg  <= '1;
            ph     <= '0;
            nbit   <= '0;
        end else if (take) begin
            active <= 1'b1;
            shreg  <= build_frame(pick.word);
            ph     <= '0;
            nbit   <= '0;
        end else if (active) begin
            ph <= last_ph ? '0 : ph + 1'b1;
            if (last_ph) begin
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                nbit  <= nbit + 1'b1;
                if (nbit == NB_W'(FRAME_W - 1)) active <= 1'b0;
            end
        end
    end

    AST_LAUNCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(tick)); // R4
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !ser_out); // R2
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && ph != '0) |-> $stable(ser_out)); // R3

endmodule

// File: rtl/fcs_serializer.sv
module fcs_serializer
    import fcs_pkg::*;
#(
    parameter int CLKS_PER_BIT = 4,
    parameter int TICK_DIV     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             cmd_ready,
    input  logic             req_stop,
    input  logic             req_start,
    input  logic             req_sync,
    input  logic             req_bufrst,
    output logic             ser_out,
    output logic             busy
);
    logic  tick, take, active, any_pend;
    pick_t pick;

    fcs_tick #(.DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    fcs_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .strobes  ({req_bufrst, req_sync, req_start, req_stop}),
        .cmd_valid(cmd_valid),
        .cmd_data (cmd_data),
        .cmd_ready(cmd_ready),
        .take     (take),
        .pick     (pick),
        .any_pend (any_pend)
    );

    fcs_shift #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .pick   (pick),
        .take   (take),
        .ser_out(ser_out),
        .active (active)
    );

    assign busy = active || any_pend;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ser_out); // R9
    AST_NO_LAUNCH_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !active) |=> !active); // R4

endmodule

// File: tb/sim_fcs_serializer.sv
module sim_fcs_serializer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic        req_stop = 1'b0, req_start = 1'b0, req_sync = 1'b0, req_bufrst = 1'b0;
    logic        ser_out, busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    fcs_serializer u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .req_stop(req_stop), .req_start(req_start), .req_sync(req_sync),
        .req_bufrst(req_bufrst), .ser_out(ser_out), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Waits for a frame start, decodes it, returns word and start edge index
    task automatic grab(output logic [15:0] w, output int start_cyc);
        int guard = 0;
        logic ok_stop;
        w = '0;
        start_cyc = -1;
        while (ser_out !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        if (ser_out !== 1'b0) begin
            check("R2 frame seen", 0, 1);
            return;
        end
        start_cyc = cyc;
        repeat (2) @(negedge clk);
        check("R3 start bit held", ser_out, 0);
        for (int j = 0; j < 16; j++) begin
            repeat (4) @(negedge clk);
            w[j] = ser_out;
        end
        ok_stop = 1'b1;
        for (int j = 0; j < 2; j++) begin
            repeat (4) @(negedge clk);
            if (ser_out !== 1'b1) ok_stop = 1'b0;
        end
        check("R2 stop bits high", ok_stop, 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: req_stop = 1'b1;
            1: req_start = 1'b1;
            2: req_sync = 1'b1;
            default: req_bufrst = 1'b1;
        endcase
        @(negedge clk);
        {req_stop, req_start, req_sync, req_bufrst} = '0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 line idle", ser_out, 1);
        check("R1 busy low", busy, 0);
        check("R1 ready high", cmd_ready, 1);
    endtask

    task automatic t_single(input int which, input logic [15:0] code, input string tag);
        logic [15:0] w;
        int s;
        pulse(which);
        check("R9 busy while pending", busy, 1);
        grab(w, s);
        check(tag, w, code);
        check("R4 start on tick", s % 8, 0);
        repeat (3) @(negedge clk);
        check("R9 busy clears", busy, 0);
        check("R2 idle high after frame", ser_out, 1);
    endtask

    task automatic t_generic;
        logic [15:0] w;
        int s;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 16'hA5C3;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 ready low after accept", cmd_ready, 0);
        grab(w, s);
        check("R6 generic word", w, 16'hA5C3);
        check("R4 start on tick", s % 8, 0);
        check("R6 ready back", cmd_ready, 1);
    endtask

    task automatic t_priority;
        logic [15:0] w;
        logic [15:0] exp_q [5];
        int s, prev;
        exp_q = '{16'hE313, 16'hE311, 16'hE000, 16'h0000, 16'h3C5A};
        @(negedge clk);
        {req_stop, req_start, req_sync, req_bufrst} = '1;
        cmd_valid = 1'b1;
        cmd_data  = 16'h3C5A;
        @(negedge clk);
        {req_stop, req_start, req_sync, req_bufrst} = '0;
        cmd_valid = 1'b0;
        prev = -1;
        for (int k = 0; k < 5; k++) begin
            grab(w, s);
            check("R7 priority order", w, exp_q[k]);
            if (prev >= 0) check("R8 back-to-back gap", s - prev, 80);
            prev = s;
        end
        repeat (3) @(negedge clk);
        check("R9 busy clears after burst", busy, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        check("watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(1, 16'hE311, "R5 start code");
        t_single(0, 16'hE313, "R5 stop code");
        t_single(2, 16'hE000, "R5 sync code");
        t_single(3, 16'h0000, "R5 buffer reset code");
        t_generic();
        t_priority();
        finish_up();
    end

endmodule